// File: doc/BRIEF.md
# Boot Guard Power-Cycle Sequencer

This block watches the first seconds after each boot. Once the host has armed it, the block opens a boot window at every start-up and expects the host to acknowledge that it booted properly by issuing a disable task before the window closes. If no acknowledgement arrives, the block runs a power-cycle sequence. It first holds the supply outputs disconnected and pulled low for a fixed time. It then holds the device in an internal reset for a fixed time, and finally re-enables the main regulator.

The arming bit sits in a retained domain. An ordinary reset leaves it intact, so the guard runs again on the next boot. Only a power-on reset or a host write of zero clears it. Every interval is counted in prescaler ticks, and the prescaler divides the block clock. The prescaler restarts whenever the sequencer changes phase, so each phase lasts an exact number of clock cycles. A two-bit status word reports whether the guard is running (bit 0) and whether it is armed (bit 1).

Top module: `boot_guard`

## Requirements
- R1: After power-on reset the guard is disarmed and idle: status reads 2'b00, disconnect and internal reset are low, and the regulator enable is high.
- R2: A write with `arm_val`=1 sets status bit 1 in the following cycle. If no disable has been accepted since the last reset, the boot window opens one cycle later and status bit 0 reads 1.
- R3: The boot window lasts exactly BOOT_TICKS×TICK_DIV clock cycles. A disable task inside it closes the window, status bit 0 reads 0 in the next cycle, and no power cycle follows.
- R4: After an accepted disable the guard stays idle, even while armed, until the next ordinary reset.
- R5: On expiry of the window, disconnect is high and the regulator enable is low for exactly OFF_TICKS×TICK_DIV cycles.
- R6: Next, internal reset is high, disconnect is low and the regulator enable is low for exactly RESET_TICKS×TICK_DIV cycles.
- R7: Then comes a single cycle in which only the regulator enable is high, then one idle cycle. If the guard is still armed, a new window opens in the cycle after that.
- R8: A disable task issued outside the boot window (while idle or during the power-cycle sequence) has no effect.
- R9: If a disable task arrives in the last cycle of the window, the disable wins and no power cycle starts.
- R10: An ordinary reset returns the sequencer to idle from any phase, which drops disconnect and internal reset and raises the regulator enable. It keeps the arming bit, and when armed a new window opens one cycle after the reset is released.
- R11: A power-on reset in any phase returns to idle and clears the arming bit. It wins over an arming write in the same cycle.
- R12: Writing `arm_val`=0 while a window runs does not stop that window. It only prevents later windows.
- R13: Disconnect and internal reset are never high together, and the regulator enable is low whenever either of them is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| por | input | 1 | Power-on reset, synchronous, active high; clears the arming bit |
| rst | input | 1 | Ordinary reset, synchronous, active high; keeps the arming bit |
| arm_wr | input | 1 | Write strobe for the arming bit |
| arm_val | input | 1 | Value written to the arming bit when `arm_wr` is high |
| host_dis | input | 1 | Host disable task, one-cycle pulse |
| stat_o | output | 2 | Bit 0: guard running; bit 1: guard armed |
| discon_o | output | 1 | Supply disconnect and active pull-down |
| core_rst_o | output | 1 | Internal device reset |
| buck_en_o | output | 1 | Main regulator enable |

## Verification
The host acknowledgement and the window expiry can fall in the same clock cycle. The bench provokes this by counting from the cycle in which status bit 0 first rises and pulsing `host_dis` in exactly the last cycle of the window. The case passes if status bit 0 drops with `discon_o` never rising. A companion case sends the same pulse one cycle later, in the first disconnect cycle. There the disable must be ignored, and the disconnect phase must still run its full remaining length.

// File: rtl/boot_guard_pkg.sv
package boot_guard_pkg;

    // Sequencer phases
    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_WAIT = 3'd1,
        PH_OFF  = 3'd2,
        PH_RST  = 3'd3,
        PH_ON   = 3'd4
    } phase_e;

    // Output drive bundle decoded from the phase
    typedef struct packed {
        logic active;
        logic discon;
        logic core_rst;
        logic buck_en;
    } drive_t;

    function automatic drive_t drive_of(phase_e p);
        drive_t d;
        d.active   = (p == PH_WAIT);
        d.discon   = (p == PH_OFF);
        d.core_rst = (p == PH_RST);
        d.buck_en  = !((p == PH_OFF) || (p == PH_RST));
        return d;
    endfunction

    // Tick span of a timed phase; untimed phases report 1
    function automatic int unsigned span_of(phase_e p, int unsigned w_ticks,
                                            int unsigned o_ticks, int unsigned r_ticks);
        case (p)
            PH_WAIT: return w_ticks;
            PH_OFF:  return o_ticks;
            PH_RST:  return r_ticks;
            default: return 1;
        endcase
    endfunction

    function automatic logic is_timed(phase_e p);
        return (p == PH_WAIT) || (p == PH_OFF) || (p == PH_RST);
    endfunction

    function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/boot_guard_presc.sv
module boot_guard_presc #(
    parameter int unsigned DIV = 8
) (
    input  logic clk,
    input  logic clr_i,
    output logic tick_o
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] cnt_q;

    assign tick_o = (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (clr_i || tick_o) cnt_q <= '0;
        else                 cnt_q <= cnt_q + 1'b1;
    end

    generate
        if (DIV > 1) begin : g_gap_chk
            // ticks are isolated pulses, so phase lengths are whole multiples of DIV
            assert_tick_gap_R3: assert property (@(posedge clk) disable iff (clr_i)
                tick_o |=> !tick_o);
        end
    endgenerate

endmodule

// File: rtl/boot_guard_ivl.sv
module boot_guard_ivl #(
    parameter int unsigned W = 4
) (
    input  logic         clk,
    input  logic         clr_i,
    input  logic         run_i,
    input  logic         tick_i,
    input  logic [W-1:0] limit_i,
    output logic         done_o
);
    logic [W-1:0] cnt_q;

    assign done_o = run_i && tick_i && (cnt_q == (limit_i - 1'b1));

    always_ff @(posedge clk) begin
        if (clr_i || done_o)      cnt_q <= '0;
        else if (run_i && tick_i) cnt_q <= cnt_q + 1'b1;
    end

    assert_cnt_in_span_R3: assert property (@(posedge clk) disable iff (clr_i)
        run_i |-> (cnt_q < limit_i));

endmodule

// File: rtl/boot_guard_arm.sv
module boot_guard_arm (
    input  logic clk,
    input  logic por_i,
    input  logic rst_i,
    input  logic wr_i,
    input  logic val_i,
    input  logic dis_ok_i,
    output logic armed_o,
    output logic served_o
);
    logic armed_q;
    logic served_q;

    // retained bit: only power-on reset clears it
    always_ff @(posedge clk) begin
        if (por_i)     armed_q <= 1'b0;
        else if (wr_i) armed_q <= val_i;
    end

    // acknowledged-this-boot flag, cleared by every reset
    always_ff @(posedge clk) begin
        if (por_i || rst_i) served_q <= 1'b0;
        else if (dis_ok_i)  served_q <= 1'b1;
    end

    assign armed_o  = armed_q;
    assign served_o = served_q;

    assert_por_clears_R11: assert property (@(posedge clk) disable iff (rst_i)
        por_i |=> !armed_q);

    assert_arm_kept_R10: assert property (@(posedge clk) disable iff (por_i)
        (rst_i && !wr_i && !$isunknown(armed_q)) |=> (armed_q == $past(armed_q)));

endmodule

// File: rtl/boot_guard_fsm.sv
module boot_guard_fsm
    import boot_guard_pkg::*;
#(
    parameter int unsigned LIM_W       = 4,
    parameter int unsigned BOOT_TICKS  = 10,
    parameter int unsigned OFF_TICKS   = 4,
    parameter int unsigned RESET_TICKS = 4
) (
    input  logic             clk,
    input  logic             por_i,
    input  logic             rst_i,
    input  logic             dis_i,
    input  logic             armed_i,
    input  logic             served_i,
    input  logic             done_i,
    output phase_e           phase_o,
    output logic             restart_o,
    output logic             dis_ok_o,
    output logic             run_o,
    output logic [LIM_W-1:0] limit_o
);
    phase_e st_q;
    phase_e nxt;

    always_comb begin
        nxt = st_q;
        unique case (st_q)
            PH_IDLE: if (armed_i && !served_i) nxt = PH_WAIT;
            PH_WAIT: begin
                if (dis_i)       nxt = PH_IDLE;   // acknowledgement beats expiry
                else if (done_i) nxt = PH_OFF;
            end
            PH_OFF:  if (done_i) nxt = PH_RST;
            PH_RST:  if (done_i) nxt = PH_ON;
            PH_ON:   nxt = PH_IDLE;
            default: nxt = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (por_i || rst_i) st_q <= PH_IDLE;
        else                st_q <= nxt;
    end

    assign phase_o   = st_q;
    assign restart_o = (nxt != st_q);
    assign dis_ok_o  = dis_i && (st_q == PH_WAIT);
    assign run_o     = is_timed(st_q);
    assign limit_o   = LIM_W'(span_of(st_q, BOOT_TICKS, OFF_TICKS, RESET_TICKS));

    assert_dis_wins_R9: assert property (@(posedge clk) disable iff (por_i || rst_i)
        (st_q == PH_WAIT && dis_i) |=> (st_q == PH_IDLE));

    assert_off_then_rst_R6: assert property (@(posedge clk) disable iff (por_i || rst_i)
        (st_q == PH_OFF) |=> (st_q == PH_OFF || st_q == PH_RST));

    assert_on_single_R7: assert property (@(posedge clk) disable iff (por_i || rst_i)
        (st_q == PH_ON) |=> (st_q == PH_IDLE));

    assert_late_dis_R8: assert property (@(posedge clk) disable iff (por_i || rst_i)
        (st_q == PH_RST && !done_i) |=> (st_q == PH_RST));

endmodule

// File: rtl/boot_guard.sv
module boot_guard
    import boot_guard_pkg::*;
#(
    parameter int unsigned TICK_DIV    = 8,
    parameter int unsigned BOOT_TICKS  = 625,
    parameter int unsigned OFF_TICKS   = 7,
    parameter int unsigned RESET_TICKS = 7
) (
    input  logic       clk,
    input  logic       por,
    input  logic       rst,
    input  logic       arm_wr,
    input  logic       arm_val,
    input  logic       host_dis,
    output logic [1:0] stat_o,
    output logic       discon_o,
    output logic       core_rst_o,
    output logic       buck_en_o
);
    localparam int unsigned SPAN_MAX = max3(BOOT_TICKS, OFF_TICKS, RESET_TICKS);
    localparam int unsigned LIM_W    = $clog2(SPAN_MAX + 1);

    phase_e           phase;
    drive_t           drv;
    logic             restart;
    logic             clr_time;
    logic             tick;
    logic             done;
    logic             run;
    logic             dis_ok;
    logic             armed;
    logic             served;
    logic [LIM_W-1:0] limit;

    assign clr_time = por || rst || restart;

    boot_guard_presc #(.DIV(TICK_DIV)) u_presc (
        .clk    (clk),
        .clr_i  (clr_time),
        .tick_o (tick)
    );

    boot_guard_ivl #(.W(LIM_W)) u_ivl (
        .clk     (clk),
        .clr_i   (clr_time),
        .run_i   (run),
        .tick_i  (tick),
        .limit_i (limit),
        .done_o  (done)
    );

    boot_guard_arm u_arm (
        .clk      (clk),
        .por_i    (por),
        .rst_i    (rst),
        .wr_i     (arm_wr),
        .val_i    (arm_val),
        .dis_ok_i (dis_ok),
        .armed_o  (armed),
        .served_o (served)
    );

    boot_guard_fsm #(
        .LIM_W       (LIM_W),
        .BOOT_TICKS  (BOOT_TICKS),
        .OFF_TICKS   (OFF_TICKS),
        .RESET_TICKS (RESET_TICKS)
    ) u_fsm (
        .clk       (clk),
        .por_i     (por),
        .rst_i     (rst),
        .dis_i     (host_dis),
        .armed_i   (armed),
        .served_i  (served),
        .done_i    (done),
        .phase_o   (phase),
        .restart_o (restart),
        .dis_ok_o  (dis_ok),
        .run_o     (run),
        .limit_o   (limit)
    );

    assign drv        = drive_of(phase);
    assign stat_o     = {armed, drv.active};
    assign discon_o   = drv.discon;
    assign core_rst_o = drv.core_rst;
    assign buck_en_o  = drv.buck_en;

    assert_excl_R13: assert property (@(posedge clk) disable iff (por || rst)
        !(discon_o && core_rst_o));

    assert_buck_low_R5: assert property (@(posedge clk) disable iff (por || rst)
        (discon_o || core_rst_o) |-> !buck_en_o);

    assert_rst_idle_R10: assert property (@(posedge clk) disable iff (por)
        rst |=> (!discon_o && !core_rst_o && buck_en_o && !stat_o[0]));

endmodule

// File: tb/boot_guard_bench.sv
module boot_guard_bench;
    localparam int DIV  = 3;
    localparam int BT   = 5;
    localparam int OT   = 4;
    localparam int RT   = 2;
    localparam int WIN  = BT * DIV;
    localparam int OFFN = OT * DIV;
    localparam int RSTN = RT * DIV;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic       por = 1'b1;
    logic       rst = 1'b0;
    logic       arm_wr = 1'b0;
    logic       arm_val = 1'b0;
    logic       host_dis = 1'b0;
    logic [1:0] stat;
    logic       discon;
    logic       core_rst;
    logic       buck_en;

    int checks = 0;
    int failures = 0;

    boot_guard #(
        .TICK_DIV(DIV), .BOOT_TICKS(BT), .OFF_TICKS(OT), .RESET_TICKS(RT)
    ) u_boot_guard (
        .clk(clk), .por(por), .rst(rst), .arm_wr(arm_wr), .arm_val(arm_val),
        .host_dis(host_dis), .stat_o(stat), .discon_o(discon),
        .core_rst_o(core_rst), .buck_en_o(buck_en)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic sig(input int sel);
        case (sel)
            0:       return stat[0];
            1:       return discon;
            default: return core_rst;
        endcase
    endfunction

    task automatic hold_len(input int sel, output int n);
        n = 0;
        while (sig(sel) === 1'b1 && n < 1000) begin
            n++;
            step();
        end
    endtask

    task automatic t_reset_state();
        check("R1 status", stat, 0);
        check("R1 disconnect", discon, 0);
        check("R1 core reset", core_rst, 0);
        check("R1 regulator", buck_en, 1);
        host_dis = 1'b1; step(); host_dis = 1'b0; step(3);
        check("R8 disable while idle", stat, 0);
    endtask

    task automatic t_arm_ack();
        int bad;
        arm_wr = 1'b1; arm_val = 1'b1; step(); arm_wr = 1'b0;
        check("R2 armed bit", stat, 2);
        step();
        check("R2 window open", stat, 3);
        step(3);
        host_dis = 1'b1; step(); host_dis = 1'b0;
        check("R3 window closed by disable", stat, 2);
        bad = 0;
        repeat (WIN + 10) begin
            step();
            if (stat !== 2'd2 || discon !== 1'b0) bad++;
        end
        check("R4 stays idle after disable", bad, 0);
    endtask

    task automatic t_full_cycle();
        int n;
        rst = 1'b1; step();
        check("R10 arming kept over reset", stat, 2);
        rst = 1'b0; step();
        check("R10 window after release", stat[0], 1);
        hold_len(0, n);
        check("R3 window length", n, WIN);
        check("R5 disconnect on expiry", discon, 1);
        check("R5 regulator off", buck_en, 0);
        hold_len(1, n);
        check("R5 disconnect length", n, OFFN);
        check("R6 internal reset", core_rst, 1);
        check("R13 disconnect low in reset", discon, 0);
        check("R6 regulator off", buck_en, 0);
        hold_len(2, n);
        check("R6 reset length", n, RSTN);
        check("R7 regulator back on", buck_en, 1);
        check("R7 others low", {discon, core_rst, stat[0]}, 0);
        step();
        check("R7 idle cycle", stat, 2);
        step();
        check("R7 new window", stat, 3);
    endtask

    task automatic t_collision();
        step(WIN - 1);
        host_dis = 1'b1; step(); host_dis = 1'b0;
        check("R9 disable wins over expiry", stat, 2);
        check("R9 no disconnect", discon, 0);
        step(OFFN);
        check("R9 still no disconnect", discon, 0);
    endtask

    task automatic t_late_dis();
        int n;
        rst = 1'b1; step(); rst = 1'b0; step();
        check("R10 window reopens", stat[0], 1);
        step(WIN);
        check("R3 expiry cycle", discon, 1);
        host_dis = 1'b1; step(); host_dis = 1'b0;
        check("R8 late disable ignored", discon, 1);
        hold_len(1, n);
        check("R8 disconnect runs on", n, OFFN - 1);
        hold_len(2, n);
        check("R6 reset length again", n, RSTN);
        step(2);
        check("R7 rearmed window", stat, 3);
    endtask

    task automatic t_clear_mid();
        int n;
        step(2);
        arm_wr = 1'b1; arm_val = 1'b0; step(); arm_wr = 1'b0;
        check("R12 cleared but running", stat, 1);
        hold_len(0, n);
        check("R12 window unchanged", n, WIN - 3);
        check("R12 power cycle still occurs", discon, 1);
        hold_len(1, n);
        hold_len(2, n);
        step(5);
        check("R12 no further window", stat, 0);
        check("R12 regulator on", buck_en, 1);
    endtask

    task automatic t_rst_in_seq();
        arm_wr = 1'b1; arm_val = 1'b1; step(); arm_wr = 1'b0; step();
        step(WIN);
        check("R5 disconnect before reset", discon, 1);
        rst = 1'b1; step();
        check("R10 disconnect dropped", discon, 0);
        check("R10 regulator on", buck_en, 1);
        check("R10 armed idle", stat, 2);
        rst = 1'b0; step();
        check("R10 window after sequence reset", stat[0], 1);
    endtask

    task automatic t_por();
        int bad;
        step(3);
        por = 1'b1; step(); por = 1'b0;
        check("R11 por in window", stat, 0);
        bad = 0;
        repeat (20) begin
            step();
            if (stat !== 2'd0 || buck_en !== 1'b1) bad++;
        end
        check("R11 stays disarmed", bad, 0);
        arm_wr = 1'b1; arm_val = 1'b1; step(); arm_wr = 1'b0; step();
        step(WIN + 2);
        check("R5 disconnect before por", discon, 1);
        por = 1'b1; step(); por = 1'b0;
        check("R11 por drops disconnect", discon, 0);
        check("R11 por regulator on", buck_en, 1);
        check("R11 por disarms", stat, 0);
        por = 1'b1; arm_wr = 1'b1; arm_val = 1'b1; step();
        por = 1'b0; arm_wr = 1'b0;
        check("R11 por beats write", stat, 0);
        step();
        check("R11 still idle", stat, 0);
    endtask

    initial begin
        step(2);
        por = 1'b0;
        t_reset_state();
        t_arm_ack();
        t_full_cycle();
        t_collision();
        t_late_dis();
        t_clear_mid();
        t_rst_in_seq();
        t_por();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        failures++;
        $display("FAIL watchdog R1 actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule